// File: doc/BRIEF.md
# Sticky-Enable Seconds Watchdog

This block is a register-programmed watchdog timer that counts whole seconds. A prescaler divides the system clock down to one tick per second. A seconds counter compares the elapsed seconds against a 4-bit timeout field. Software arms the watchdog by setting a single enable bit. After that, no write can disarm it, and only a system reset returns it to the idle state. Every write to the control register restarts the count, whatever data the write carries. Software keeps the system alive by writing the control register periodically. It normally uses a read-modify-write so that the timeout and enable fields keep their values.

When the programmed number of seconds passes without a write, the block asserts a reset request for a fixed number of clock cycles. It also sets a reset-cause flag. This flag sits in a separate reset domain that only the power-on reset clears, so the boot code can still read it after the system reset that the watchdog caused. Software clears the flag by writing 1 to it.

Top module: `sticky_wdog`

## Requirements
- R1: After a power-on reset, the reset request is low, and both the control register and the status register read 0. The watchdog does not count.
- R2: Writing 1 to control bit 7 enables the watchdog. A later write with bit 7 at 0 leaves it enabled. Only the system reset (`rstN` low) clears the enable bit.
- R3: Any write to the control register restarts the countdown, whatever data it carries. This includes the prescaler phase. A write in the same cycle as an expiry wins, and no expiry occurs.
- R4: Control bits 11:8 hold the timeout T in seconds. The first cycle of the reset request comes exactly T×CLK_HZ clock cycles after the write edge that last restarted the count.
- R5: A timeout field of 0 behaves as a 1-second timeout.
- R6: A new timeout written while the watchdog runs takes effect at once. It is measured from that write.
- R7: On expiry, `rstReq` stays high for exactly PULSE_LEN cycles. While it is high, counting is frozen. The count then restarts from zero, as if a write had occurred on the last edge of the pulse.
- R8: Status bit 31 reads 1 after a watchdog expiry. A system reset does not clear it, and neither does a status write with bit 31 at 0. A status write with bit 31 at 1 clears it, and so does a power-on reset (`porN` low).
- R9: While the enable bit is 0, no expiry occurs and the reset-cause flag stays 0, however long the block is left alone.
- R10: The control register reads back the timeout in bits 11:8 and the enable in bit 7. All other bits read 0. The control register sits at address CTRL_OFS and the status register at STAT_OFS. Reads are combinational from `regAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Active-low power-on reset. Clears everything, including the reset-cause flag |
| rstN | input | 1 | Active-low system reset. Clears the enable, the timeout and the counters |
| regWrEn | input | 1 | Single-cycle register write strobe |
| regAddr | input | ADDR_W | Register byte address for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| rstReq | output | 1 | System reset request, high for PULSE_LEN cycles after an expiry |

## Verification
The hardest situation to reach from the ports is a keep-alive write that lands on the very edge on which the count would expire. The stimulus gets there by writing at an interval that equals the timeout exactly, so each write falls on the expiry edge, and `rstReq` must stay low. The other hard case is the flag surviving a system reset. The stimulus lets the watchdog fire, pulses `rstN` on its own, and reads the status register before and after a power-on reset. The timeout field is swept over all 16 values with a 4-cycle second, so each expiry cycle count can be computed exactly.

// File: rtl/sticky_wdog_pkg.sv
package sticky_wdog_pkg;

  localparam int unsigned EnBit    = 7;
  localparam int unsigned TmoLsb   = 8;
  localparam int unsigned TmoW     = 4;
  localparam int unsigned CauseBit = 31;

  typedef struct packed {
    logic kick;      // restart prescaler and seconds count
    logic loadCtrl;  // capture enable/timeout fields
    logic clrCause;  // write-one-to-clear of the cause flag
    logic hold;      // reset pulse in progress, freeze counting
    logic rdCtrl;    // read select: control register
    logic rdStat;    // read select: status register
  } wdStrobe_t;

endpackage

// File: rtl/sticky_wdog_ctrl.sv
module sticky_wdog_ctrl
  import sticky_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h14,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h18,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrCauseBit,
  input  logic              expire,
  input  logic              enabled,
  output wdStrobe_t         strb,
  output logic              rstReq
);

  localparam int unsigned PL_W = $clog2(PULSE_LEN + 1);
  localparam logic [PL_W-1:0] PL_LOAD = PL_W'(PULSE_LEN);

  logic hitCtrl;
  logic hitStat;
  logic [PL_W-1:0] pulseCnt;

  assign hitCtrl = (regAddr == CTRL_OFS);
  assign hitStat = (regAddr == STAT_OFS);

  always_comb begin
    strb          = '0;
    strb.kick     = regWrEn & hitCtrl;
    strb.loadCtrl = regWrEn & hitCtrl;
    strb.clrCause = regWrEn & hitStat & wrCauseBit;
    strb.hold     = (pulseCnt != '0);
    strb.rdCtrl   = hitCtrl;
    strb.rdStat   = hitStat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (expire) begin
      pulseCnt <= PL_LOAD;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign rstReq = (pulseCnt != '0);

  // R4
  req_after_expire_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> $past(expire));

  // R7
  no_expire_in_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> !expire);

  // R9
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> enabled);

endmodule

// File: rtl/sticky_wdog_dp.sv
module sticky_wdog_dp
  import sticky_wdog_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            porN,
  input  wdStrobe_t       strb,
  input  logic            wrEnBit,
  input  logic [TmoW-1:0] wrTmo,
  output logic            expire,
  output logic            enabled,
  output logic [31:0]     rdData
);

  localparam int unsigned PRE_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_HZ - 1);
  localparam int unsigned SEC_W = TmoW + 1;

  logic            enReg;
  logic [TmoW-1:0] tmoReg;
  logic [PRE_W-1:0] pre;
  logic [SEC_W-1:0] secCnt;
  logic [SEC_W-1:0] effTmo;
  logic            causeFlag;
  logic            tick;
  logic            restart;

  // Field registers, cleared by the system reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      tmoReg <= '0;
    end else if (strb.loadCtrl) begin
      enReg  <= enReg | wrEnBit;
      tmoReg <= wrTmo;
    end
  end

  assign effTmo  = (tmoReg == '0) ? SEC_W'(1) : {1'b0, tmoReg};
  assign restart = strb.kick | strb.hold | ~enReg;
  assign tick    = ~restart & (pre == PRE_LAST);
  assign expire  = tick & ((secCnt + 1'b1) >= effTmo);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre    <= '0;
      secCnt <= '0;
    end else if (restart) begin
      pre    <= '0;
      secCnt <= '0;
    end else if (tick) begin
      pre    <= '0;
      secCnt <= expire ? '0 : secCnt + 1'b1;
    end else begin
      pre    <= pre + 1'b1;
    end
  end

  // Cause flag lives in the power-on domain only.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      causeFlag <= 1'b0;
    end else if (expire) begin
      causeFlag <= 1'b1;
    end else if (strb.clrCause) begin
      causeFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdCtrl) begin
      rdData[EnBit]                 = enReg;
      rdData[TmoLsb +: TmoW]        = tmoReg;
    end else if (strb.rdStat) begin
      rdData[CauseBit]              = causeFlag;
    end
  end

  assign enabled = enReg;

  // R2
  sticky_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(enReg) |-> enReg);

  // R3
  kick_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.kick) |-> (secCnt == '0 && pre == '0));

  // R8
  cause_clear_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(causeFlag) |-> $past(strb.clrCause));

  // R9
  idle_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |=> (secCnt == '0));

endmodule

// File: rtl/sticky_wdog.sv
module sticky_wdog
  import sticky_wdog_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned PULSE_LEN = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h14,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h18
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              rstReq
);

  wdStrobe_t strb;
  logic expire;
  logic enabled;
  logic unusedWrBits;

  assign unusedWrBits = ^{regWrData[30:TmoLsb+TmoW], regWrData[EnBit-1:0]};

  sticky_wdog_ctrl #(
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .STAT_OFS (STAT_OFS),
    .PULSE_LEN(PULSE_LEN)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .wrCauseBit(regWrData[CauseBit]),
    .expire    (expire),
    .enabled   (enabled),
    .strb      (strb),
    .rstReq    (rstReq)
  );

  sticky_wdog_dp #(
    .CLK_HZ(CLK_HZ)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .porN   (porN),
    .strb   (strb),
    .wrEnBit(regWrData[EnBit]),
    .wrTmo  (regWrData[TmoLsb +: TmoW]),
    .expire (expire),
    .enabled(enabled),
    .rdData (regRdData)
  );

endmodule

// File: tb/tb_sticky_wdog.sv
`timescale 1ns/1ps
module tb_sticky_wdog;

  localparam int HZ = 4;
  localparam int PL = 16;
  localparam logic [7:0] A_CTRL = 8'h14;
  localparam logic [7:0] A_STAT = 8'h18;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rstReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  sticky_wdog #(.CLK_HZ(HZ), .PULSE_LEN(PL)) dut (
    .clk(clk), .porN(porN), .rstN(rstN), .regWrEn(wrEn), .regAddr(addr),
    .regWrData(wdata), .regRdData(rdata), .rstReq(rstReq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  // cycles from the last restart edge to the first sample with rstReq high
  task automatic measure(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rstReq) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic pulseLen(output int c);
    c = 1;
    while (c < 1000) begin
      @(posedge clk);
      @(negedge clk);
      if (rstReq) c++;
      else break;
    end
  endtask

  task automatic sysRst();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic powerOn();
    @(negedge clk);
    porN = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    int c;

    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rstReq", {31'b0, rstReq}, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_STAT, v); chk("R1 stat", v, 32'h0);

    // R9 disabled: timeout 1 s, enable 0
    wr(A_CTRL, 32'h0000_0100);
    measure(40, n); chk("R9 no expiry", n, 0);
    rd(A_STAT, v); chk("R9 cause stays 0", v, 32'h0);
    rd(A_CTRL, v); chk("R10 ctrl readback", v, 32'h0000_0100);

    // R4 R5 R7 R8 sweep over every timeout value
    for (int t = 0; t < 16; t++) begin
      int expN;
      expN = ((t == 0) ? 1 : t) * HZ;
      sysRst();
      wr(A_CTRL, (t << 8) | 32'h80);
      measure(100, n); chk((t == 0) ? "R5 zero timeout" : "R4 expiry cycle", n, expN);
      pulseLen(c); chk("R7 pulse length", c, PL);
      measure(100, n); chk("R7 restart after pulse", n, expN);
      pulseLen(c);
      rd(A_STAT, v); chk("R8 cause set", v, 32'h8000_0000);
      sysRst();
      rd(A_STAT, v); chk("R8 survives system reset", v, 32'h8000_0000);
      wr(A_STAT, 32'h7FFF_FFFF);
      rd(A_STAT, v); chk("R8 write 0 keeps flag", v, 32'h8000_0000);
      wr(A_STAT, 32'h8000_0000);
      rd(A_STAT, v); chk("R8 write 1 clears", v, 32'h0);
    end

    // R2 R3 R10 sticky enable and kick with arbitrary data
    sysRst();
    wr(A_CTRL, 32'h0000_0380);
    repeat (7) @(negedge clk);
    wr(A_CTRL, 32'hFFFF_F37F);
    rd(A_CTRL, v); chk("R2 enable sticky", v, 32'h0000_0380);
    measure(40, n); chk("R3 kick reloads", n, 3 * HZ);
    pulseLen(c);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R2 enable kept by zero write", v, 32'h0000_0080);
    measure(40, n); chk("R5 zero timeout running", n, HZ);
    pulseLen(c);

    // R3 kicks landing exactly on the expiry edge
    sysRst();
    wr(A_CTRL, 32'h0000_0380);
    for (int k = 0; k < 5; k++) begin
      measure(10, n); chk("R3 boundary kick", n, 0);
      wr(A_CTRL, 32'h0000_0300);
    end
    measure(40, n); chk("R3 after last kick", n, 3 * HZ);
    pulseLen(c);

    // R6 timeout changed while running
    sysRst();
    wr(A_CTRL, 32'h0000_0880);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h0000_0280);
    measure(60, n); chk("R6 new timeout", n, 2 * HZ);
    pulseLen(c);

    // R2 system reset clears enable
    sysRst();
    rd(A_CTRL, v); chk("R2 cleared by rstN", v, 32'h0);

    // R8 power-on reset clears the flag
    rd(A_STAT, v); chk("R8 flag before por", v, 32'h8000_0000);
    powerOn();
    rd(A_STAT, v); chk("R8 cleared by porN", v, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule